// File: doc/BRIEF.md
# Dual-Buffer Ethernet Frame Transmitter

This block is a memory-mapped transmit engine holding two frame buffers that software fills in turn. Software writes a frame as little-endian 32-bit words into one buffer, writes that buffer's length register, and then writes its control register to start the send. The engine streams the frame out one byte per transfer on a valid/ready byte interface, lowest byte of each word first. A buffer's control register reads busy from the start until the frame has left. Preamble, FCS and the PHY are handled by later stages.

When both buffers have been started, the engine drains them in the order they were started. A special control code on the first buffer copies its first six bytes into a station-address register instead of sending anything. Each buffer has its own completion-interrupt enable. Together with a global enable, it produces a one-clock interrupt pulse when that buffer's operation finishes.

Top module: `frame_tx_dual`

## Requirements
- R1: After reset, both control registers, both length registers and the global enable register read 0, `txValid` and `irq` are 0, and `macAddr` is 0.
- R2: Byte address 0x000 upward is the first buffer and 0x800 upward is the second buffer. Word k of a buffer holds frame bytes 4k..4k+3, with byte 4k in bits 7:0. Bus accesses whose address bits 1:0 are nonzero are ignored.
- R3: The length registers sit at 0x7F4 (first buffer) and 0xFF4 (second buffer) and read back their value in bits 10:0. A length write above 1514 is ignored. 1514 itself is accepted.
- R4: Writing control bit 0 = 1 (control at 0x7FC or 0xFFC) sends exactly the programmed number of bytes, in order, with `txLast` on the final byte only. Control bit 0 reads 1 from the cycle after that write until the cycle after the final byte is accepted.
- R5: While `txValid` is high and `txReady` is low, `txValid`, `txData` and `txLast` hold their values.
- R6: Starting a buffer whose length is 0 emits no byte and clears its busy bit.
- R7: Writing 1 to bits 1 and 0 together of the first buffer's control loads `macAddr` from bytes 0..5 of that buffer, with byte 0 in bits 7:0. No byte is emitted, and bits 1:0 read 2'b11 until the copy is done. On the second buffer the same code is a plain start, and `macAddr` does not change.
- R8: Control bit 3 is the buffer's completion-interrupt enable and reads back. Bit 31 of the register at 0x7F8 is the global interrupt enable and reads back.
- R9: `irq` is high for exactly one clock, in the cycle after a buffer's busy bit clears. This happens only if that buffer's bit 3 and the global enable are both 1.
- R10: When both buffers are started, their frames leave in start order. The second frame starts only after the first frame's last byte.
- R11: While a buffer is busy, writes to its data words, its length register and its control register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address for both writes and reads |
| busWe | input | 1 | Write strobe, one word per cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the register at `busAddr` (buffer words read 0) |
| txValid | output | 1 | Byte on `txData` is valid |
| txData | output | 8 | Frame byte |
| txLast | output | 1 | Final byte of the frame |
| txReady | input | 1 | Downstream accepts the byte |
| irq | output | 1 | One-clock completion pulse |
| macAddr | output | 48 | Station address, byte 0 in bits 7:0 |

## Verification
The assertions check on every cycle that an interrupt pulse lasts one clock and follows the clearing of some busy bit, and that a stalled byte holds steady. They also check that a valid byte appears only while some buffer is busy, that the last flag never stands without valid, and that the station address changes only while an address load is pending. Only the bench scenarios can show the rest. That covers byte content and order across buffers and lengths, the start-order rule between the two buffers, and the ignored writes to busy buffers and oversized lengths. It also covers the gating of the pulse by the two enables, the empty frame, and the byte placement of the loaded address.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;
  localparam int unsigned NUM_BUF = 2;
  localparam int unsigned CTL_GO  = 0;
  localparam int unsigned CTL_MAC = 1;
  localparam int unsigned CTL_IE  = 3;
  localparam int unsigned GIE_BIT = 31;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_MAC} txState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wordWe;   // store bus word into buffer wrBuf
    logic lenWe;    // store length into buffer wrBuf
    logic wrBuf;
    logic startTx;  // begin streaming buffer txBuf
    logic txBuf;
    logic macCopy;  // capture station address from first buffer
  } dpStrobe_t;
endpackage

// File: rtl/frame_tx_ctrl.sv
module frame_tx_ctrl
  import frame_tx_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned MAX_FRAME = 1514,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned LEN_W     = 11
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [ADDR_W-1:0]               busAddr,
  input  logic                            busWe,
  input  logic [31:0]                     busWrData,
  output logic [31:0]                     busRdData,
  input  logic [NUM_BUF-1:0][LEN_W-1:0]   bankLen,
  input  logic                            txDone,
  output dpStrobe_t                       strobe,
  output logic                            irq,
  output logic [NUM_BUF-1:0]              busyVec,
  output logic                            macPend
);
  localparam int unsigned OFF_W = ADDR_W - 1;
  localparam logic [OFF_W-1:0] LEN_OFF = OFF_W'(BUF_BYTES - 12);
  localparam logic [OFF_W-1:0] GIE_OFF = OFF_W'(BUF_BYTES - 8);
  localparam logic [OFF_W-1:0] CTL_OFF = OFF_W'(BUF_BYTES - 4);

  txState_t           state;
  logic               curBuf;
  logic [NUM_BUF-1:0] pend;
  logic [NUM_BUF-1:0] ie;
  logic               gie;
  logic               olderBuf;
  logic               pick;

  logic             aligned, wrSel;
  logic [OFF_W-1:0] offAl;
  logic             hitLen, hitGie, hitCtl, hitWord, lenOk, ctlWrOk;

  assign aligned = (busAddr[1:0] == 2'b00);
  assign wrSel   = busAddr[ADDR_W-1];
  assign offAl   = {busAddr[OFF_W-1:2], 2'b00};
  assign hitLen  = aligned && (offAl == LEN_OFF);
  assign hitGie  = aligned && (offAl == GIE_OFF) && !wrSel;
  assign hitCtl  = aligned && (offAl == CTL_OFF);
  assign hitWord = aligned && (offAl < LEN_OFF);
  assign lenOk   = (busWrData <= 32'(MAX_FRAME));
  assign ctlWrOk = busWe && hitCtl && !pend[wrSel];

  // oldest pending buffer wins
  assign pick = (pend == 2'b11) ? olderBuf : pend[1];

  assign busyVec = pend;

  always_comb begin
    strobe         = '0;
    strobe.wordWe  = busWe && hitWord && !pend[wrSel];
    strobe.lenWe   = busWe && hitLen && !pend[wrSel] && lenOk;
    strobe.wrBuf   = wrSel;
    strobe.txBuf   = pick;
    if (state == ST_IDLE && (|pend)) begin
      if (!pick && macPend) strobe.macCopy = 1'b1;
      else                  strobe.startTx = 1'b1;
    end
  end

  always_comb begin
    busRdData = '0;
    if (hitLen)      busRdData = 32'(bankLen[wrSel]);
    else if (hitGie) busRdData = {gie, 31'b0};
    else if (hitCtl) busRdData = {28'b0, ie[wrSel], 1'b0, macPend & ~wrSel, pend[wrSel]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      curBuf   <= 1'b0;
      pend     <= '0;
      ie       <= '0;
      gie      <= 1'b0;
      olderBuf <= 1'b0;
      macPend  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (busWe && hitGie) gie <= busWrData[GIE_BIT];
      if (ctlWrOk) begin
        ie[wrSel] <= busWrData[CTL_IE];
        if (busWrData[CTL_GO]) begin
          pend[wrSel] <= 1'b1;
          olderBuf    <= pend[!wrSel] ? !wrSel : wrSel;
          if (!wrSel && busWrData[CTL_MAC]) macPend <= 1'b1;
        end
      end
      unique case (state)
        ST_IDLE: begin
          if (|pend) begin
            curBuf <= pick;
            state  <= (!pick && macPend) ? ST_MAC : ST_SEND;
          end
        end
        ST_SEND: begin
          if (txDone) begin
            pend[curBuf] <= 1'b0;
            irq          <= ie[curBuf] & gie;
            state        <= ST_IDLE;
          end
        end
        ST_MAC: begin
          pend[curBuf] <= 1'b0;
          macPend      <= 1'b0;
          irq          <= ie[curBuf] & gie;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/frame_tx_datapath.sv
module frame_tx_datapath
  import frame_tx_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned LEN_W     = 11,
  localparam int unsigned WORDS    = BUF_BYTES / 4,
  localparam int unsigned WIDX_W   = $clog2(WORDS)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [WIDX_W-1:0]              wrIdx,
  input  logic [31:0]                    busWrData,
  input  dpStrobe_t                      strobe,
  input  logic                           txReady,
  output logic                           txValid,
  output logic [7:0]                     txData,
  output logic                           txLast,
  output logic                           txDone,
  output logic [NUM_BUF-1:0][LEN_W-1:0]  bankLen,
  output logic [47:0]                    macAddr
);
  logic              active;
  logic              curBuf;
  logic [LEN_W-1:0]  byteIdx;
  logic [WIDX_W-1:0] rdIdx;
  logic [31:0]       rdWord [NUM_BUF];
  logic [47:0]       macSrc;
  logic [31:0]       wordSel;
  logic [LEN_W-1:0]  curLen;
  logic [7:0]        byteVal;

  assign rdIdx = WIDX_W'(byteIdx >> 2);

  for (genvar g = 0; g < NUM_BUF; g++) begin : gBank
    logic [31:0]      mem [WORDS];
    logic [LEN_W-1:0] lenReg;

    always_ff @(posedge clk) begin
      if (strobe.wordWe && (strobe.wrBuf == 1'(g))) mem[wrIdx] <= busWrData;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) lenReg <= '0;
      else if (strobe.lenWe && (strobe.wrBuf == 1'(g))) lenReg <= busWrData[LEN_W-1:0];
    end

    assign bankLen[g] = lenReg;
    assign rdWord[g]  = mem[rdIdx];

    if (g == 0) begin : gHead
      assign macSrc = {mem[1][15:0], mem[0]};
    end
  end

  assign wordSel = rdWord[curBuf];
  assign curLen  = bankLen[curBuf];

  always_comb begin
    unique case (byteIdx[1:0])
      2'd0: byteVal = wordSel[7:0];
      2'd1: byteVal = wordSel[15:8];
      2'd2: byteVal = wordSel[23:16];
      default: byteVal = wordSel[31:24];
    endcase
  end

  assign txValid = active && (curLen != '0);
  assign txLast  = txValid && (byteIdx == curLen - 1'b1);
  assign txData  = txValid ? byteVal : 8'h00;
  assign txDone  = active && ((curLen == '0) || (txValid && txReady && txLast));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      curBuf  <= 1'b0;
      byteIdx <= '0;
      macAddr <= '0;
    end else begin
      if (strobe.startTx) begin
        active  <= 1'b1;
        curBuf  <= strobe.txBuf;
        byteIdx <= '0;
      end else if (txDone) begin
        active <= 1'b0;
      end else if (txValid && txReady) begin
        byteIdx <= byteIdx + 1'b1;
      end
      if (strobe.macCopy) macAddr <= macSrc;
    end
  end
endmodule

// File: rtl/frame_tx_dual.sv
module frame_tx_dual
  import frame_tx_pkg::*;
#(
  parameter int unsigned BUF_BYTES = 2048,
  parameter int unsigned MAX_FRAME = 1514,
  localparam int unsigned ADDR_W   = $clog2(2 * BUF_BYTES),
  localparam int unsigned LEN_W    = $clog2(MAX_FRAME + 1),
  localparam int unsigned WIDX_W   = $clog2(BUF_BYTES / 4)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic              txLast,
  input  logic              txReady,
  output logic              irq,
  output logic [47:0]       macAddr
);
  dpStrobe_t                      strobe;
  logic                           txDone;
  logic [NUM_BUF-1:0][LEN_W-1:0]  bankLen;
  logic [NUM_BUF-1:0]             busyVec;
  logic                           macPend;

  frame_tx_ctrl #(
    .BUF_BYTES(BUF_BYTES), .MAX_FRAME(MAX_FRAME), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWrData(busWrData),
    .busRdData(busRdData), .bankLen(bankLen), .txDone(txDone), .strobe(strobe),
    .irq(irq), .busyVec(busyVec), .macPend(macPend)
  );

  frame_tx_datapath #(
    .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .wrIdx(busAddr[WIDX_W+1:2]), .busWrData(busWrData),
    .strobe(strobe), .txReady(txReady), .txValid(txValid), .txData(txData),
    .txLast(txLast), .txDone(txDone), .bankLen(bankLen), .macAddr(macAddr)
  );
endmodule

// File: rtl/frame_tx_dual_chk.sv
module frame_tx_dual_chk (
  input logic        clk,
  input logic        rstN,
  input logic        txValid,
  input logic        txReady,
  input logic [7:0]  txData,
  input logic        txLast,
  input logic        irq,
  input logic [1:0]  busyVec,
  input logic        macPend,
  input logic [47:0] macAddr
);
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);  // R9
  AST_IRQ_AFTER_FINISH: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (($past(busyVec) & ~busyVec) != 2'b00));  // R9
  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txLast)));  // R5
  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> (busyVec != 2'b00));  // R4
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    txLast |-> txValid);  // R4
  AST_MAC_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(macAddr) |-> $past(macPend));  // R7
endmodule

bind frame_tx_dual frame_tx_dual_chk chk_i (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady), .txData(txData),
  .txLast(txLast), .irq(irq), .busyVec(busyVec), .macPend(macPend), .macAddr(macAddr)
);

// File: tb/frame_tx_dual_tb_top.sv
module frame_tx_dual_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] LEN_OFF = 12'h7F4;
  localparam logic [11:0] GIE_ADR = 12'h7F8;
  localparam logic [11:0] CTL_OFF = 12'h7FC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        txValid, txLast, irq;
  logic [7:0]  txData;
  logic        txReady = 1'b0;
  logic [47:0] macAddr;

  int checks = 0, fails = 0, cyc = 0, readyMode = 0;
  logic [7:0] rxBuf [4096];
  logic       rxLastQ [4096];
  int rxCount = 0, irqCount = 0, irqWide = 0;
  logic irqPrev = 1'b0;

  frame_tx_dual dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busWrData(busWrData),
    .busRdData(busRdData), .txValid(txValid), .txData(txData), .txLast(txLast),
    .txReady(txReady), .irq(irq), .macAddr(macAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ready pattern and output monitor, away from the rising edge
  always @(negedge clk) begin
    cyc++;
    case (readyMode)
      0: txReady = 1'b1;
      1: txReady = (cyc % 2 == 0);
      2: txReady = (cyc % 3 == 0);
      default: txReady = 1'b0;
    endcase
    if (rstN && txValid && txReady && rxCount < 4096) begin
      rxBuf[rxCount] = txData;
      rxLastQ[rxCount] = txLast;
      rxCount++;
    end
    if (irq) irqCount++;
    if (irq && irqPrev) irqWide++;
    irqPrev = irq;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int b, int seed, int i);
    return 8'((seed + i * 29 + b * 101) & 255);
  endfunction

  function automatic logic [11:0] base(int b);
    return (b != 0) ? 12'h800 : 12'h000;
  endfunction

  task automatic busWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    busAddr = a;
    #1 v = busRdData;
  endtask

  task automatic fillBuf(int b, int seed, int n);
    for (int w = 0; w < (n + 3) / 4; w++) begin
      logic [31:0] d;
      d = {pat(b, seed, 4*w+3), pat(b, seed, 4*w+2), pat(b, seed, 4*w+1), pat(b, seed, 4*w)};
      busWrite(base(b) + 12'(4 * w), d);
    end
  endtask

  task automatic waitIdle(int b);
    logic [31:0] v;
    for (int k = 0; k < 20000; k++) begin
      busRead(base(b) + CTL_OFF, v);
      if (v[1:0] == 2'b00) break;
    end
    repeat (2) @(negedge clk);
  endtask

  // compare received bytes [at, at+n) against the pattern of buffer b
  task automatic cmpBytes(string req, int b, int seed, int n, int at);
    int badB = 0, badL = 0;
    for (int i = 0; i < n; i++) begin
      if (rxBuf[at+i] != pat(b, seed, i)) badB++;
      if (rxLastQ[at+i] != (i == n - 1)) badL++;
    end
    chk(req, "byte mismatches", badB, 0);
    chk("R4", "last flag mismatches", badL, 0);
  endtask

  task automatic sendFrame(int b, int n, int seed, logic [31:0] ctlVal, int mode, bit gieOn);
    logic [31:0] v;
    int irq0;
    readyMode = mode;
    fillBuf(b, seed, n);
    busWrite(base(b) + LEN_OFF, 32'(n));
    busRead(base(b) + LEN_OFF, v);
    chk("R3", "length readback", v, n);
    rxCount = 0;
    irq0 = irqCount;
    busWrite(base(b) + CTL_OFF, ctlVal);
    busRead(base(b) + CTL_OFF, v);
    chk("R4", "busy after start", v[0], 1);
    waitIdle(b);
    chk("R4", "byte count", rxCount, n);
    cmpBytes("R2", b, seed, n, 0);
    chk("R9", "irq pulses", irqCount - irq0, (ctlVal[3] && gieOn) ? 1 : 0);
  endtask

  task automatic orderTest(int first, int seedF, int seedS);
    logic [31:0] v;
    int second = 1 - first;
    int nF = 5 + 2 * first, nS = 5 + 2 * second;
    readyMode = 3;
    fillBuf(first, seedF, nF);
    fillBuf(second, seedS, nS);
    busWrite(base(first) + LEN_OFF, 32'(nF));
    busWrite(base(second) + LEN_OFF, 32'(nS));
    rxCount = 0;
    busWrite(base(first) + CTL_OFF, 32'h1);
    busWrite(base(second) + CTL_OFF, 32'h1);
    @(negedge clk); #1;
    chk("R5", "stalled valid", txValid, 1);
    chk("R5", "stalled byte", txData, pat(first, seedF, 0));
    repeat (3) @(negedge clk); #1;
    chk("R5", "stalled byte held", txData, pat(first, seedF, 0));
    // writes to busy buffers must be dropped
    busWrite(base(first), 32'hDEADBEEF);
    busWrite(base(second), 32'hCAFEF00D);
    busWrite(base(first) + LEN_OFF, 32'd3);
    busWrite(base(first) + CTL_OFF, 32'h8);
    busRead(base(first) + LEN_OFF, v);
    chk("R11", "busy length kept", v, nF);
    busRead(base(first) + CTL_OFF, v);
    chk("R11", "busy control kept", v, 32'h1);
    busRead(base(second) + CTL_OFF, v);
    chk("R10", "queued buffer busy", v[0], 1);
    readyMode = 0;
    waitIdle(first);
    waitIdle(second);
    chk("R10", "total bytes", rxCount, nF + nS);
    cmpBytes("R10", first, seedF, nF, 0);
    cmpBytes("R10", second, seedS, nS, nF);
  endtask

  initial begin
    logic [31:0] v;
    int irq0;
    logic [47:0] expMac;
    int lens [14] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 60, 61, 62, 63, 1514};

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(12'h000 + CTL_OFF, v); chk("R1", "ctl A", v, 0);
    busRead(12'h800 + CTL_OFF, v); chk("R1", "ctl B", v, 0);
    busRead(12'h000 + LEN_OFF, v); chk("R1", "len A", v, 0);
    busRead(12'h800 + LEN_OFF, v); chk("R1", "len B", v, 0);
    busRead(GIE_ADR, v);           chk("R1", "gie", v, 0);
    chk("R1", "txValid", txValid, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "macAddr", macAddr, 0);

    // R8 enable readback
    busWrite(CTL_OFF, 32'h8);
    busRead(CTL_OFF, v); chk("R8", "ie readback", v, 32'h8);
    busWrite(CTL_OFF, 32'h0);
    busRead(CTL_OFF, v); chk("R8", "ie cleared", v, 32'h0);
    busWrite(GIE_ADR, 32'h8000_0000);
    busRead(GIE_ADR, v); chk("R8", "gie readback", v, 32'h8000_0000);

    // R3 length limits, R2 misaligned ignored
    busWrite(LEN_OFF, 32'd100);
    busWrite(LEN_OFF, 32'd1515);
    busRead(LEN_OFF, v); chk("R3", "oversize ignored", v, 100);
    busWrite(LEN_OFF, 32'd2047);
    busRead(LEN_OFF, v); chk("R3", "2047 ignored", v, 100);
    busWrite(LEN_OFF + 12'd1, 32'd20);
    busRead(LEN_OFF, v); chk("R2", "misaligned write ignored", v, 100);

    // sweep: both buffers, three ready patterns, many lengths (R2 R4 R5 R9)
    for (int b = 0; b < 2; b++)
      for (int m = 0; m < 3; m++)
        foreach (lens[li])
          sendFrame(b, lens[li], 7 * li + 3 * m + b, (lens[li] % 2 == 0) ? 32'h9 : 32'h1, m, 1'b1);

    // R6 empty frame
    busWrite(12'h800 + LEN_OFF, 32'd0);
    rxCount = 0; irq0 = irqCount;
    busWrite(12'h800 + CTL_OFF, 32'h9);
    waitIdle(1);
    chk("R6", "no bytes for empty frame", rxCount, 0);
    chk("R6", "empty frame irq", irqCount - irq0, 1);

    // R9 gating by global enable
    busWrite(GIE_ADR, 32'h0);
    sendFrame(0, 10, 77, 32'h9, 0, 1'b0);
    busWrite(GIE_ADR, 32'h8000_0000);
    sendFrame(1, 10, 78, 32'h1, 0, 1'b1);

    // R10 start order, R11 busy writes, R5 stall
    orderTest(1, 11, 22);
    orderTest(0, 33, 44);

    // R7 station address load
    readyMode = 0;
    fillBuf(0, 50, 8);
    expMac = {pat(0,50,5), pat(0,50,4), pat(0,50,3), pat(0,50,2), pat(0,50,1), pat(0,50,0)};
    rxCount = 0; irq0 = irqCount;
    busWrite(CTL_OFF, 32'h3);
    busRead(CTL_OFF, v); chk("R7", "bits 1:0 while loading", v[1:0], 2'b11);
    waitIdle(0);
    chk("R7", "macAddr loaded", macAddr, expMac);
    chk("R7", "no bytes on load", rxCount, 0);
    chk("R9", "no irq without ie", irqCount - irq0, 0);
    fillBuf(0, 90, 8);
    busWrite(CTL_OFF, 32'hB);
    waitIdle(0);
    chk("R9", "irq on load with ie", irqCount - irq0, 1);
    expMac = {pat(0,90,5), pat(0,90,4), pat(0,90,3), pat(0,90,2), pat(0,90,1), pat(0,90,0)};
    chk("R7", "macAddr reloaded", macAddr, expMac);
    sendFrame(1, 4, 61, 32'h3, 0, 1'b1);
    chk("R7", "second buffer code 3 keeps macAddr", macAddr, expMac);

    chk("R9", "irq wider than one clock", irqWide, 0);
    summary();
    $finish;
  end
endmodule